// File: doc/BRIEF.md
# Non-Volatile Memory Image Checksum Engine

This block sits on the word-read and word-write port of a memory that holds 16-bit words. When it gets a start pulse, it walks the stored image from word 0 upward, one word at a time. It keeps a running sum of the words in 16 bits, so any carry past bit 15 is dropped.

In check mode, the sum covers every word up to and including the checksum word. The image is good only when that sum equals the signature 0xBABA. In update mode, the sum stops one word short of the checksum word. The engine then writes the signature minus that partial sum into the checksum word, so a later check passes.

A read error or a write error ends the sequence at once and raises the error flag. The result appears with a one-cycle done pulse and stays visible until the next start.

Top module: `nvm_csum_engine`

## Requirements
- R1: The running sum is a 16-bit addition in which carries out of bit 15 are discarded.
- R2: In check mode (modeUpdate=0), words 0 to CSUM_IDX (default 63) are read in ascending order. Only one read is outstanding at a time. rdReq and rdAddr stay steady until rdAck, and the next address is requested only after that ack.
- R3: In check mode, pass=1 and err=0 when the sum equals 0xBABA. Otherwise pass=0 and err=0. No write is issued in check mode.
- R4: In update mode (modeUpdate=1), only words 0 to CSUM_IDX-1 are read. One write then goes to address CSUM_IDX with data (0xBABA - sum) mod 2^16. A write acked without wrErr yields pass=1 and err=0.
- R5: A read acked with rdErr=1 ends the sequence. No further read is issued and no write is issued. The run finishes with err=1 and pass=0.
- R6: A write acked with wrErr=1 finishes the run with err=1 and pass=0.
- R7: A start pulse that arrives while a sequence is running has no effect on that sequence.
- R8: done is high for exactly one cycle, in the cycle after the ack that ends the run. pass and err keep their values until the next accepted start.
- R9: After reset, rdReq, wrReq, done, pass and err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the engine is idle |
| modeUpdate | input | 1 | 0 = check the image, 1 = rewrite the checksum word |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Check matched, or update written |
| err | output | 1 | Read or write error ended the run |
| rdReq | output | 1 | Read request, held until rdAck |
| rdAddr | output | ADDR_W | Word address being read |
| rdAck | input | 1 | Read completion, one cycle |
| rdErr | input | 1 | Read failed, valid with rdAck |
| rdData | input | DATA_W | Read word, valid with rdAck |
| wrReq | output | 1 | Write request, held until wrAck |
| wrAddr | output | ADDR_W | Write address (always the checksum word) |
| wrData | output | DATA_W | Checksum word to be written |
| wrAck | input | 1 | Write completion, one cycle |
| wrErr | input | 1 | Write failed, valid with wrAck |

## Verification
The bench uses large word values, so the sum wraps many times. An engine that widened the sum, or compared it before truncating it, would reject a good image. It counts reads in both modes; an off-by-one on the last index would show as 63 reads in check mode, or as the checksum word itself being folded into the update sum. A read error is injected partway through, and a write error is injected on the final write. An engine that kept reading, or reported success anyway, would show extra reads or pass=1. A second start arrives during a slow run. An engine that restarted or switched mode would issue extra reads or an unexpected write.

// File: rtl/nvm_csum_pkg.sv
package nvm_csum_pkg;
  // Strobes from the sequencer to the datapath, at most a few per cycle.
  typedef struct packed {
    logic clear;        // new run accepted
    logic accumulate;   // good read word arrived
    logic advance;      // step to next address
    logic finishCheck;  // last check-mode word arrived
    logic finishWrite;  // checksum write acknowledged without error
    logic fail;         // read or write error
  } csStrobe_t;
endpackage

// File: rtl/nvm_csum_ctrl.sv
module nvm_csum_ctrl
  import nvm_csum_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      modeUpdate,
  input  logic      rdAck,
  input  logic      rdErr,
  input  logic      wrAck,
  input  logic      wrErr,
  input  logic      isLast,
  output logic      rdReq,
  output logic      wrReq,
  output logic      done,
  output logic      updMode,
  output csStrobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} csState_e;

  csState_e state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strobe.clear = 1'b1;
          stateNext    = S_READ;
        end
      end
      S_READ: begin
        if (rdAck) begin
          if (rdErr) begin
            strobe.fail = 1'b1;
            stateNext   = S_IDLE;
          end else begin
            strobe.accumulate = 1'b1;
            if (isLast) begin
              if (updMode) begin
                stateNext = S_WRITE;
              end else begin
                strobe.finishCheck = 1'b1;
                stateNext          = S_IDLE;
              end
            end else begin
              strobe.advance = 1'b1;
            end
          end
        end
      end
      S_WRITE: begin
        if (wrAck) begin
          if (wrErr) strobe.fail        = 1'b1;
          else       strobe.finishWrite = 1'b1;
          stateNext = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      updMode <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.fail | strobe.finishCheck | strobe.finishWrite;
      if (strobe.clear) updMode <= modeUpdate;
    end
  end

  assign rdReq = (state == S_READ);
  assign wrReq = (state == S_WRITE);
endmodule

// File: rtl/nvm_csum_dp.sv
module nvm_csum_dp
  import nvm_csum_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          CSUM_IDX  = 63,
  parameter int          ADDR_W    = 6,
  parameter logic [15:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk,
  input  logic              rstN,
  input  csStrobe_t         strobe,
  input  logic              updMode,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] addr,
  output logic              isLast,
  output logic [DATA_W-1:0] wrData,
  output logic              pass,
  output logic              err
);
  localparam logic [ADDR_W-1:0] LAST_CHECK  = ADDR_W'(CSUM_IDX);
  localparam logic [ADDR_W-1:0] LAST_UPDATE = ADDR_W'(CSUM_IDX - 1);
  localparam logic [DATA_W-1:0] SIG_W       = DATA_W'(SIGNATURE);

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] sumNext;

  // Carry beyond DATA_W is dropped by the width of the result.
  assign sumNext = sum + rdData;
  assign isLast  = (addr == (updMode ? LAST_UPDATE : LAST_CHECK));
  assign wrData  = SIG_W - sum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sum  <= '0;
      addr <= '0;
      pass <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (strobe.clear) begin
        sum  <= '0;
        addr <= '0;
        pass <= 1'b0;
        err  <= 1'b0;
      end else begin
        if (strobe.accumulate)  sum  <= sumNext;
        if (strobe.advance)     addr <= addr + 1'b1;
        if (strobe.finishCheck) pass <= (sumNext == SIG_W);
        if (strobe.finishWrite) pass <= 1'b1;
        if (strobe.fail) begin
          pass <= 1'b0;
          err  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nvm_csum_engine.sv
module nvm_csum_engine
  import nvm_csum_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          CSUM_IDX  = 63,
  parameter logic [15:0] SIGNATURE = 16'hBABA,
  localparam int         ADDR_W    = (CSUM_IDX < 1) ? 1 : $clog2(CSUM_IDX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeUpdate,
  output logic              done,
  output logic              pass,
  output logic              err,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic              rdErr,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrAck,
  input  logic              wrErr
);
  csStrobe_t strobe;
  logic      updMode;
  logic      isLast;

  nvm_csum_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .modeUpdate(modeUpdate),
    .rdAck(rdAck), .rdErr(rdErr), .wrAck(wrAck), .wrErr(wrErr),
    .isLast(isLast), .rdReq(rdReq), .wrReq(wrReq), .done(done),
    .updMode(updMode), .strobe(strobe)
  );

  nvm_csum_dp #(
    .DATA_W(DATA_W), .CSUM_IDX(CSUM_IDX), .ADDR_W(ADDR_W), .SIGNATURE(SIGNATURE)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .updMode(updMode),
    .rdData(rdData), .addr(rdAddr), .isLast(isLast), .wrData(wrData),
    .pass(pass), .err(err)
  );

  assign wrAddr = ADDR_W'(CSUM_IDX);
endmodule

// File: rtl/nvm_csum_chk.sv
module nvm_csum_chk #(
  parameter int DATA_W   = 16,
  parameter int CSUM_IDX = 63,
  parameter int ADDR_W   = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic              pass,
  input logic              err,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdAck,
  input logic              rdErr,
  input logic              wrReq,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wrAck,
  input logic              wrErr
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && wrReq)); // R2

  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdAddr))); // R2

  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdReq) |-> (rdAddr == '0)); // R2

  AST_RD_ERR_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdAck && rdErr) |=> (!rdReq && !wrReq && done && err && !pass)); // R5

  AST_WR_ERR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && wrAck && wrErr) |=> (done && err && !pass)); // R6

  AST_WR_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> (wrAddr == ADDR_W'(CSUM_IDX))); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck && start) |=> rdReq); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!rdReq && !wrReq && !start && !$past(start)) |=> ($stable(pass) && $stable(err))); // R8
endmodule

bind nvm_csum_engine nvm_csum_chk #(
  .DATA_W(DATA_W), .CSUM_IDX(CSUM_IDX), .ADDR_W(ADDR_W)
) uChk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .pass(pass), .err(err),
  .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdErr(rdErr),
  .wrReq(wrReq), .wrAddr(wrAddr), .wrAck(wrAck), .wrErr(wrErr)
);

// File: tb/tb_nvm_csum_engine.sv
`timescale 1ns/1ps
module tb_nvm_csum_engine;
  localparam int DATA_W = 16;
  localparam int IDX    = 63;
  localparam int AW     = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, modeUpdate = 1'b0;
  logic done, pass, err, rdReq, wrReq;
  logic [AW-1:0] rdAddr, wrAddr;
  logic [DATA_W-1:0] wrData;
  logic rdAck = 1'b0, rdErr = 1'b0, wrAck = 1'b0, wrErr = 1'b0;
  logic [DATA_W-1:0] rdData = '0;

  always #4 clk = ~clk;

  nvm_csum_engine dut (
    .clk(clk), .rstN(rstN), .start(start), .modeUpdate(modeUpdate),
    .done(done), .pass(pass), .err(err),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdErr(rdErr), .rdData(rdData),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrAck(wrAck), .wrErr(wrErr)
  );

  logic [15:0] mem [0:IDX];
  int nChecks = 0, nFails = 0;
  int rdLat = 0, rdErrAddr = -1, rdCount = 0, expAddr = 0, orderBad = 0;
  int wrCount = 0;
  bit wrErrInj = 1'b0;
  logic [AW-1:0] lastWrAddr;
  logic [15:0] lastWrData;
  logic resPass, resErr;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Read responder
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (rdAck) begin
        rdAck = 1'b0; rdErr = 1'b0; waitCnt = 0;
      end else if (rdReq) begin
        if (waitCnt >= rdLat) begin
          rdAck  = 1'b1;
          rdData = mem[rdAddr];
          rdErr  = (int'(rdAddr) == rdErrAddr);
          if (int'(rdAddr) != expAddr) orderBad++;
          expAddr++;
          rdCount++;
          waitCnt = 0;
        end else waitCnt++;
      end
    end
  end

  // Write responder
  initial begin
    forever begin
      @(negedge clk);
      if (wrAck) begin
        wrAck = 1'b0; wrErr = 1'b0;
      end else if (wrReq) begin
        wrAck = 1'b1;
        wrErr = wrErrInj;
        lastWrAddr = wrAddr;
        lastWrData = wrData;
        wrCount++;
        if (!wrErrInj) mem[wrAddr] = wrData;
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic pulseStart(input logic mode);
    @(negedge clk);
    start = 1'b1; modeUpdate = mode;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    check(done == 1'b1, req, "done seen", done, 1);
    resPass = pass; resErr = err;
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", done, 0);
  endtask

  task automatic runOp(input logic mode, input string req);
    rdCount = 0; expAddr = 0; orderBad = 0; wrCount = 0;
    pulseStart(mode);
    waitDone(req);
  endtask

  function automatic logic [15:0] sumTo(input int last);
    logic [15:0] s = '0;
    for (int i = 0; i <= last; i++) s = s + mem[i];
    return s;
  endfunction

  task automatic fillGood(input logic [15:0] seed);
    for (int i = 0; i < IDX; i++) mem[i] = 16'hE000 | (seed ^ 16'(i * 16'h0531));
    mem[IDX] = 16'hBABA - sumTo(IDX - 1);
  endtask

  task automatic testReset();
    check(!rdReq && !wrReq, "R9", "no request after reset", {rdReq, wrReq}, 0);
    check(!done && !pass && !err, "R9", "flags after reset", {done, pass, err}, 0);
  endtask

  task automatic testCheckGood();
    rdLat = 1; fillGood(16'h1234);
    runOp(1'b0, "R3");
    check(resPass == 1'b1 && resErr == 1'b0, "R1", "wrapped sum matches", {resPass, resErr}, 2);
    check(rdCount == IDX + 1, "R2", "read count check mode", rdCount, IDX + 1);
    check(orderBad == 0, "R2", "ascending addresses", orderBad, 0);
    check(wrCount == 0, "R3", "no write in check mode", wrCount, 0);
  endtask

  task automatic testCheckBad();
    rdLat = 0; fillGood(16'h0F0F);
    mem[17] = mem[17] + 16'h0001;
    runOp(1'b0, "R3");
    check(resPass == 1'b0 && resErr == 1'b0, "R3", "mismatch result", {resPass, resErr}, 0);
    check(rdCount == IDX + 1, "R2", "read count on mismatch", rdCount, IDX + 1);
  endtask

  task automatic testUpdate();
    logic [15:0] expW;
    rdLat = 2;
    for (int i = 0; i <= IDX; i++) mem[i] = 16'hF00D ^ 16'(i * 16'h3A7);
    expW = 16'hBABA - sumTo(IDX - 1);
    runOp(1'b1, "R4");
    check(rdCount == IDX, "R4", "read count update mode", rdCount, IDX);
    check(wrCount == 1, "R4", "one write", wrCount, 1);
    check(int'(lastWrAddr) == IDX, "R4", "write address", lastWrAddr, IDX);
    check(lastWrData == expW, "R4", "written checksum", lastWrData, expW);
    check(resPass == 1'b1 && resErr == 1'b0, "R4", "update result", {resPass, resErr}, 2);
    runOp(1'b0, "R4");
    check(resPass == 1'b1, "R4", "image checks after update", resPass, 1);
  endtask

  task automatic testReadErr();
    rdLat = 1; fillGood(16'h5555); rdErrAddr = 10;
    runOp(1'b0, "R5");
    check(rdCount == 11, "R5", "reads stop at error", rdCount, 11);
    check(resErr == 1'b1 && resPass == 1'b0, "R5", "read error flags", {resPass, resErr}, 1);
    rdErrAddr = IDX - 1;
    runOp(1'b1, "R5");
    check(wrCount == 0, "R5", "no write after read error", wrCount, 0);
    check(resErr == 1'b1 && resPass == 1'b0, "R5", "update read error", {resPass, resErr}, 1);
    rdErrAddr = -1;
  endtask

  task automatic testWriteErr();
    logic [15:0] oldW;
    rdLat = 0; fillGood(16'h7777); mem[IDX] = 16'h0000; oldW = mem[IDX];
    wrErrInj = 1'b1;
    runOp(1'b1, "R6");
    check(wrCount == 1, "R6", "write attempted", wrCount, 1);
    check(resErr == 1'b1 && resPass == 1'b0, "R6", "write error flags", {resPass, resErr}, 1);
    check(mem[IDX] == oldW, "R6", "word unchanged", mem[IDX], oldW);
    wrErrInj = 1'b0;
  endtask

  task automatic testBusy();
    rdLat = 3; fillGood(16'h2468);
    rdCount = 0; expAddr = 0; orderBad = 0; wrCount = 0;
    pulseStart(1'b0);
    repeat (20) @(negedge clk);
    pulseStart(1'b1);
    repeat (7) @(negedge clk);
    pulseStart(1'b0);
    waitDone("R7");
    check(rdCount == IDX + 1, "R7", "run unaffected by start", rdCount, IDX + 1);
    check(orderBad == 0, "R7", "no restart of addresses", orderBad, 0);
    check(wrCount == 0, "R7", "mode not switched", wrCount, 0);
    check(resPass == 1'b1, "R7", "result of original run", resPass, 1);
  endtask

  task automatic testHold();
    rdLat = 0; fillGood(16'h9999);
    runOp(1'b0, "R8");
    repeat (6) @(negedge clk);
    check(pass == 1'b1 && err == 1'b0, "R8", "result held", {pass, err}, 2);
    check(done == 1'b0, "R8", "done stays low", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCheckGood();
    testCheckBad();
    testUpdate();
    testReadErr();
    testWriteErr();
    testBusy();
    testHold();
    finish_run();
  end
endmodule